// File: doc/BRIEF.md
# Triangle Frequency Sweep Engine

This block produces the tuning word for a direct digital synthesizer and integrates it into a phase value. A ramp accumulator holds an offset above a base ("mark") frequency word. In ramped FSK mode the offset climbs by a programmable step until the output reaches the "space" frequency word. With triangle sweeping enabled it then falls back to the mark word and repeats indefinitely. A chirp mode lets the offset grow without bound.

Two clear controls shape the sweep from outside. A one-cycle ramp clear drops the ramp offset to zero and restarts the sweep from the mark word. The phase is left running, so a host that pulses it periodically in chirp mode gets a sawtooth frequency ramp. A level-held clear forces both the ramp offset and the phase to zero for as long as it is high, so the phase can be started from a known value.

Top module: `fsk_sweep_engine`

## Requirements
- R1: While `rst` is high, and until the first clock edge after it falls, both `freq_word` and `phase_acc` read zero.
- R2: On every clock edge without hold clear, `phase_acc` becomes its previous value plus the previous `freq_word`, modulo 2^FW (FW = 48 by default).
- R3: `mode_sel` encodes 2'b00 fixed, 2'b01 ramped FSK, 2'b10 chirp and 2'b11 reserved. In fixed or reserved mode, `freq_word` equals the `mark_freq` value sampled at the previous edge.
- R4: While a sweep runs, the ramp offset changes once every N clock edges, where N is `ramp_rate` (0 counts as 1). The first change falls on the Nth edge after the sweep starts.
- R5: In ramped FSK mode with `tri_en` high, the offset rises by `step_size` and is clamped to exactly `space_freq - mark_freq`. On the following steps it falls by `step_size` and is clamped to exactly zero, and this repeats. `space_freq >= mark_freq` is assumed.
- R6: In ramped FSK mode with `tri_en` low, the offset rises by `step_size` to the space value and then holds there.
- R7: With `tri_en` high and a mode other than ramped FSK, the offset is held at zero, so `freq_word` stays at the mark word.
- R8: In chirp mode with `tri_en` low, each step adds `step_size` to the offset without clamping. `freq_word` is `mark_freq` plus the offset, modulo 2^FW.
- R9: In any mode, an edge with `clr_ramp_pulse` high sets the offset to zero, sets the direction to rising and restarts the step timer. `freq_word` then equals the mark word, and `phase_acc` keeps accumulating.
- R10: On each edge while `clr_hold` is high, `phase_acc` becomes zero, `freq_word` becomes the mark word, and the sweep timer and direction are reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mark_freq | input | FW | Lower sweep end / base frequency word |
| space_freq | input | FW | Upper sweep end frequency word |
| step_size | input | FW | Offset change per ramp step |
| ramp_rate | input | RW | Clock edges per ramp step (0 acts as 1) |
| mode_sel | input | 2 | Operating mode: 00 fixed, 01 ramped FSK, 10 chirp, 11 reserved |
| tri_en | input | 1 | Continuous up/down sweep enable |
| clr_ramp_pulse | input | 1 | One-cycle clear of the ramp offset |
| clr_hold | input | 1 | Level-held clear of ramp offset and phase |
| freq_word | output | FW | Registered frequency word |
| phase_acc | output | FW | Registered phase accumulator |

## Verification
`freq_word` is registered from the next ramp offset, so a ramp step is visible on the same edge that the timer fires. A sweep started by releasing `clr_hold` therefore shows its first step after exactly N edges. `phase_acc` trails `freq_word` by one edge, because it adds the word that was present before the edge. Every check releases or drives inputs on a falling edge, counts the rising edges that have passed, and samples on the next falling edge. The expected value is the number of steps completed in that window, traced through the clamp points.

// File: rtl/fsk_sweep_pkg.sv
package fsk_sweep_pkg;

  typedef enum logic [1:0] {
    MODE_FIXED = 2'b00,
    MODE_RAMP  = 2'b01,
    MODE_CHIRP = 2'b10,
    MODE_RSVD  = 2'b11
  } sweep_mode_e;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } sweep_dir_e;

endpackage

// File: rtl/sweep_rate_timer.sv
// Produces one tick every N enabled cycles, N = rate (0 treated as 1).
module sweep_rate_timer #(
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [RW-1:0] rate,
  output logic          tick
);

  logic [RW-1:0] cnt_q;
  logic [RW-1:0] last_cnt;

  always_comb begin
    if (rate == '0) last_cnt = '0;
    else            last_cnt = rate - 1'b1;
  end

  assign tick = run && (cnt_q >= last_cnt);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/ramp_accumulator.sv
// Ramp offset above the mark word, with clamped triangle reversal or free chirp.
module ramp_accumulator
  import fsk_sweep_pkg::*;
#(
  parameter int FW = 48
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  logic        tick,
  input  sweep_mode_e mode,
  input  logic        tri_on,
  input  logic [FW-1:0] span,
  input  logic [FW-1:0] step,
  output logic [FW-1:0] acc_next,
  output logic [FW-1:0] acc_q
);

  sweep_dir_e  dir_q, dir_next;
  logic [FW:0] up_sum;
  logic        rising;

  assign up_sum = {1'b0, acc_q} + {1'b0, step};
  assign rising = (dir_q == DIR_UP) || !tri_on;

  always_comb begin
    acc_next = acc_q;
    dir_next = dir_q;
    if (clear) begin
      acc_next = '0;
      dir_next = DIR_UP;
    end else if (tick) begin
      unique case (mode)
        MODE_RAMP: begin
          if (rising) begin
            if (up_sum >= {1'b0, span}) begin
              acc_next = span;
              dir_next = tri_on ? DIR_DOWN : DIR_UP;
            end else begin
              acc_next = up_sum[FW-1:0];
            end
          end else begin
            if (acc_q <= step) begin
              acc_next = '0;
              dir_next = DIR_UP;
            end else begin
              acc_next = acc_q - step;
            end
          end
        end
        MODE_CHIRP: acc_next = up_sum[FW-1:0];
        default:    acc_next = acc_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      dir_q <= DIR_UP;
    end else begin
      acc_q <= acc_next;
      dir_q <= dir_next;
    end
  end

endmodule

// File: rtl/phase_accumulator.sv
// Modulo 2^PW phase integrator with a level clear.
module phase_accumulator #(
  parameter int PW = 48
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic [PW-1:0] inc,
  output logic [PW-1:0] phase_q
);

  always_ff @(posedge clk) begin
    if (rst || clear) phase_q <= '0;
    else              phase_q <= phase_q + inc;
  end

endmodule

// File: rtl/fsk_sweep_engine.sv
module fsk_sweep_engine
  import fsk_sweep_pkg::*;
#(
  parameter int FW = 48,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] mark_freq,
  input  logic [FW-1:0] space_freq,
  input  logic [FW-1:0] step_size,
  input  logic [RW-1:0] ramp_rate,
  input  logic [1:0]    mode_sel,
  input  logic          tri_en,
  input  logic          clr_ramp_pulse,
  input  logic          clr_hold,
  output logic [FW-1:0] freq_word,
  output logic [FW-1:0] phase_acc
);

  sweep_mode_e   mode;
  logic          sweeping_mode;
  logic          tri_idle;
  logic          acc_clear;
  logic          timer_run;
  logic          ramp_tick;
  logic [FW-1:0] span;
  logic [FW-1:0] acc_next;
  logic [FW-1:0] acc_q;
  logic [FW-1:0] freq_q;

  assign mode          = sweep_mode_e'(mode_sel);
  assign sweeping_mode = (mode == MODE_RAMP) || (mode == MODE_CHIRP);
  assign tri_idle      = tri_en && (mode != MODE_RAMP);
  assign acc_clear     = clr_hold || clr_ramp_pulse || tri_idle || !sweeping_mode;
  assign timer_run     = !acc_clear;
  assign span          = space_freq - mark_freq;

  sweep_rate_timer #(.RW(RW)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (timer_run),
    .rate (ramp_rate),
    .tick (ramp_tick)
  );

  ramp_accumulator #(.FW(FW)) u_ramp (
    .clk      (clk),
    .rst      (rst),
    .clear    (acc_clear),
    .tick     (ramp_tick),
    .mode     (mode),
    .tri_on   (tri_en),
    .span     (span),
    .step     (step_size),
    .acc_next (acc_next),
    .acc_q    (acc_q)
  );

  always_ff @(posedge clk) begin
    if (rst) freq_q <= '0;
    else     freq_q <= mark_freq + acc_next;
  end

  phase_accumulator #(.PW(FW)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .clear   (clr_hold),
    .inc     (freq_q),
    .phase_q (phase_acc)
  );

  assign freq_word = freq_q;

endmodule

// File: rtl/fsk_sweep_engine_chk.sv
module fsk_sweep_engine_chk #(
  parameter int FW = 48
) (
  input logic          clk,
  input logic          rst,
  input logic [FW-1:0] mark_freq,
  input logic [1:0]    mode_sel,
  input logic          tri_en,
  input logic          clr_ramp_pulse,
  input logic          clr_hold,
  input logic          step_tick,
  input logic [FW-1:0] freq_word,
  input logic [FW-1:0] phase_acc
);

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (freq_word == '0 && phase_acc == '0));

  // R2
  phase_integrate_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_hold |=> phase_acc == $past(phase_acc) + $past(freq_word));

  // R3
  fixed_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b00 || mode_sel == 2'b11) |=> freq_word == $past(mark_freq));

  // R4
  tick_gate_chk: assert property (@(posedge clk) disable iff (rst)
    step_tick |-> ((mode_sel == 2'b01 || mode_sel == 2'b10) && !clr_hold && !clr_ramp_pulse));

  // R7
  tri_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (tri_en && mode_sel != 2'b01) |=> freq_word == $past(mark_freq));

  // R9
  pulse_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_ramp_pulse |=> freq_word == $past(mark_freq));

  // R10
  hold_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_hold |=> (phase_acc == '0 && freq_word == $past(mark_freq)));

endmodule

bind fsk_sweep_engine fsk_sweep_engine_chk #(.FW(FW)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .mark_freq      (mark_freq),
  .mode_sel       (mode_sel),
  .tri_en         (tri_en),
  .clr_ramp_pulse (clr_ramp_pulse),
  .clr_hold       (clr_hold),
  .step_tick      (ramp_tick),
  .freq_word      (freq_word),
  .phase_acc      (phase_acc)
);

// File: tb/fsk_sweep_engine_tb.sv
module fsk_sweep_engine_tb;

  localparam int FW = 48;
  localparam int RW = 16;

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  mode;
    logic        tri_on;
    logic [47:0] mark;
    logic [47:0] space;
    logic [47:0] step;
    logic [15:0] rate;
    logic [15:0] ncyc;
    logic [47:0] expv;
  } vec_t;

  // Each vector: hold-clear for one edge, release, then ncyc edges, then compare freq_word.
  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{4'd5, 2'd1, 1'b1, 48'd1000, 48'd1100, 48'd30, 16'd2, 16'd8,  48'd1100}, // R5 top clamp
    '{4'd5, 2'd1, 1'b1, 48'd1000, 48'd1100, 48'd30, 16'd2, 16'd10, 48'd1070}, // R5 falling
    '{4'd5, 2'd1, 1'b1, 48'd1000, 48'd1100, 48'd30, 16'd2, 16'd16, 48'd1000}, // R5 bottom clamp
    '{4'd5, 2'd1, 1'b1, 48'd1000, 48'd1100, 48'd30, 16'd2, 16'd18, 48'd1030}, // R5 rising again
    '{4'd6, 2'd1, 1'b0, 48'd1000, 48'd1100, 48'd30, 16'd1, 16'd10, 48'd1100}, // R6 hold at space
    '{4'd4, 2'd1, 1'b1, 48'd1000, 48'd1100, 48'd30, 16'd0, 16'd2,  48'd1060}, // R4 rate 0 as 1
    '{4'd4, 2'd1, 1'b0, 48'd1000, 48'd1100, 48'd30, 16'd5, 16'd4,  48'd1000}, // R4 before Nth edge
    '{4'd4, 2'd1, 1'b0, 48'd1000, 48'd1100, 48'd30, 16'd5, 16'd5,  48'd1030}, // R4 on Nth edge
    '{4'd8, 2'd2, 1'b0, 48'd1000, 48'd1100, 48'd5,  16'd3, 16'd9,  48'd1015}, // R8 chirp
    '{4'd7, 2'd2, 1'b1, 48'd1000, 48'd1100, 48'd5,  16'd3, 16'd9,  48'd1000}, // R7 chirp + tri idle
    '{4'd3, 2'd0, 1'b0, 48'd1000, 48'd1100, 48'd5,  16'd1, 16'd5,  48'd1000}, // R3 fixed
    '{4'd3, 2'd3, 1'b0, 48'd1000, 48'd1100, 48'd5,  16'd1, 16'd5,  48'd1000}, // R3 reserved
    '{4'd5, 2'd1, 1'b1, 48'd1000, 48'd1010, 48'd30, 16'd1, 16'd2,  48'd1000}, // R5 step > span
    '{4'd5, 2'd1, 1'b1, 48'd1000, 48'd1010, 48'd30, 16'd1, 16'd3,  48'd1010}, // R5 step > span
    '{4'd8, 2'd2, 1'b0, 48'hFFFF_FFFF_FFF6, 48'd0, 48'd4, 16'd1, 16'd3, 48'd2} // R8 wrap
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [FW-1:0] mark_freq = '0;
  logic [FW-1:0] space_freq = '0;
  logic [FW-1:0] step_size = '0;
  logic [RW-1:0] ramp_rate = '0;
  logic [1:0]    mode_sel = 2'b00;
  logic          tri_en = 1'b0;
  logic          clr_ramp_pulse = 1'b0;
  logic          clr_hold = 1'b0;
  logic [FW-1:0] freq_word;
  logic [FW-1:0] phase_acc;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  fsk_sweep_engine #(.FW(FW), .RW(RW)) u_dut (
    .clk            (clk),
    .rst            (rst),
    .mark_freq      (mark_freq),
    .space_freq     (space_freq),
    .step_size      (step_size),
    .ramp_rate      (ramp_rate),
    .mode_sel       (mode_sel),
    .tri_en         (tri_en),
    .clr_ramp_pulse (clr_ramp_pulse),
    .clr_hold       (clr_hold),
    .freq_word      (freq_word),
    .phase_acc      (phase_acc)
  );

  task automatic check(input string req, input logic [FW-1:0] act, input logic [FW-1:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic setup(input logic [1:0] m, input logic t, input logic [FW-1:0] mk,
                       input logic [FW-1:0] sp, input logic [FW-1:0] st, input logic [RW-1:0] rt);
    @(negedge clk);
    mode_sel = m; tri_en = t; mark_freq = mk; space_freq = sp; step_size = st; ramp_rate = rt;
    clr_hold = 1'b1;
    @(negedge clk);
    clr_hold = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs zero during and right after reset
    check("R1", freq_word, '0);
    check("R1", phase_acc, '0);
    rst = 1'b0;
    check("R1", freq_word, '0);
    check("R1", phase_acc, '0);

    for (int i = 0; i < NV; i++) begin
      setup(VECS[i].mode, VECS[i].tri_on, VECS[i].mark, VECS[i].space, VECS[i].step, VECS[i].rate[RW-1:0]);
      repeat (int'(VECS[i].ncyc)) @(negedge clk);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), freq_word, VECS[i].expv);
    end

    // R2: phase integrates a constant word
    setup(2'b00, 1'b0, 48'd5, 48'd0, 48'd0, 16'd1);
    repeat (4) @(negedge clk);
    check("R2 accumulate", phase_acc, 48'd20);

    // R2: phase wraps modulo 2^48
    setup(2'b00, 1'b0, 48'hFFFF_FFFF_FFFD, 48'd0, 48'd0, 16'd1);
    repeat (2) @(negedge clk);
    check("R2 wrap", phase_acc, 48'hFFFF_FFFF_FFFA);

    // R9: one-shot clear in chirp, phase keeps running (sawtooth restart)
    setup(2'b10, 1'b0, 48'd1000, 48'd0, 48'd5, 16'd1);
    repeat (4) @(negedge clk);
    check("R8 chirp", freq_word, 48'd1020);
    check("R2 chirp phase", phase_acc, 48'd4030);
    clr_ramp_pulse = 1'b1;
    @(negedge clk);
    clr_ramp_pulse = 1'b0;
    check("R9 freq", freq_word, 48'd1000);
    check("R9 phase", phase_acc, 48'd5050);
    @(negedge clk);
    check("R9 restart", freq_word, 48'd1005);
    check("R9 phase", phase_acc, 48'd6050);

    // R9: one-shot clear while falling in triangle resets direction to rising
    setup(2'b01, 1'b1, 48'd1000, 48'd1100, 48'd30, 16'd1);
    repeat (5) @(negedge clk);
    check("R5 falling", freq_word, 48'd1070);
    clr_ramp_pulse = 1'b1;
    @(negedge clk);
    clr_ramp_pulse = 1'b0;
    check("R9 tri clear", freq_word, 48'd1000);
    @(negedge clk);
    check("R9 dir up", freq_word, 48'd1030);

    // R10: hold clear keeps both accumulators at zero
    setup(2'b01, 1'b1, 48'd1000, 48'd1100, 48'd30, 16'd1);
    repeat (3) @(negedge clk);
    check("R5 rising", freq_word, 48'd1090);
    clr_hold = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10 phase", phase_acc, '0);
      check("R10 freq", freq_word, 48'd1000);
    end
    clr_hold = 1'b0;
    @(negedge clk);
    check("R10 release phase", phase_acc, 48'd1000);
    check("R10 release freq", freq_word, 48'd1030);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule